// File: doc/BRIEF.md
# Rotating-Priority Interrupt Controller

This block gathers 64 interrupt request lines and presents them to a processor as two outputs: a normal interrupt (IRQ) and a fast interrupt (FIQ). Every line has its own one-byte control register. That byte holds the enable, the trigger style (high level, rising edge or falling edge) and the destination. The block synchronizes each line, captures it into a pending bit and routes the enabled pending sources to their output.

For each output there is a priority register. Software reads it to learn which source to service. With rotation off, the lowest-numbered candidate wins. With rotation on, the search resumes just after the source that software last serviced, so that busy low-numbered sources cannot starve the others. A handler reads the priority register, services the source it names, and then writes a one to that source's status bit. That write clears an edge-captured request and moves the rotation pointer forward. The idle reading is 63, the same value as a real request on source 63, so software tells the two apart by checking the status bit of source 63.

Accesses use a simple single-cycle register bus with four byte lanes. Reads are combinational from the address.

Top module: `irq_vec_ctrl`

## Requirements
- R1: After reset, every control byte and every status bit reads 0, both priority registers read 0x3F (rotation off, idle code), and `irq_o` and `fiq_o` are low.
- R2: The control byte of source n lives at byte address 0x40+n, in word 0x40+4*(n/4), lane n%4. Bits 2:0 hold the destination (0 = IRQ, 1 = FIQ), bit 3 holds the enable (1 = enabled), bits 6:5 hold the trigger, and bits 7 and 4 are stored as written. Each lane is written only when its byte enable is set, and all eight bits read back as written.
- R3: In level mode (trigger bits 00), the status bit of a source follows its input three clock edges after the input changes. While the input stays high, writing a one to the status bit leaves it set.
- R4: In rising mode (bit 5 only), a low-to-high input transition sets the status bit, and the bit stays set after the input falls. Writing a one clears it. Source n<32 has its status bit at bit n of word 0x80; source n≥32 has it at bit n-32 of word 0x84.
- R5: In falling mode (bit 6 only), only a high-to-low transition sets the status bit. With both trigger bits set, either transition sets it.
- R6: `irq_o` is high exactly when some enabled, pending source has destination 0, and `fiq_o` is high exactly when some enabled, pending source has destination 1. Disabled sources and destinations 2 to 7 drive neither output, but their control byte and status bit are still kept.
- R7: With rotation off, bits 5:0 read from 0x20 (IRQ) or 0x24 (FIQ) give the lowest-numbered source that is enabled, pending and routed to that output.
- R8: When no source is a candidate for an output, its priority field reads 63. Status bit 31 of word 0x84 shows whether source 63 itself is pending.
- R9: Bit 6 of a priority register turns on rotation. The search then begins one past the pointer and wraps from 63 to 0. The pointer is 63 after reset. When software writes a one to the status bit of the source the register is currently reporting, the pointer moves to that source.
- R10: The two outputs have separate rotation bits and separate pointers. Bit 6 of each register reads back as written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | 64 | Asynchronous interrupt request lines, bit n = source n |
| bus_addr | input | 8 | Byte address; bits 1:0 are ignored |
| bus_wr | input | 1 | Write strobe, taken at the clock edge |
| bus_be | input | 4 | Byte-lane enables for writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The assertions assume that reset is applied before the first check and that request lines are not driven until reset has been released. They also assume that any request pulse lasts at least two clock periods, so that the synchronizer sees it. The bench changes request lines only on falling clock edges, holds every edge pulse high for three cycles, and waits at least four cycles after any change before it reads status. Each write is held for exactly one rising edge, so every clear write reaches the rotation pointer only once.

// File: rtl/ic_pkg.sv
package ic_pkg;

    localparam int NSRC = 64;
    localparam int IDW  = $clog2(NSRC);

    // one control byte per source
    typedef struct packed {
        logic       spare7;
        logic       trig_fall;
        logic       trig_rise;
        logic       spare4;
        logic       en;
        logic [2:0] dest;
    } ic_ctrl_t;

    typedef enum logic [2:0] {
        DST_IRQ = 3'd0,
        DST_FIQ = 3'd1
    } ic_dest_e;

    typedef struct packed {
        logic           vld;
        logic [IDW-1:0] id;
    } ic_pick_t;

    // lowest set bit of a request vector
    function automatic ic_pick_t first_set(input logic [NSRC-1:0] v);
        ic_pick_t r;
        r = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (v[i]) begin
                r.vld = 1'b1;
                r.id  = IDW'(i);
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/ic_src_chan.sv
module ic_src_chan #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic src_i,
    input  logic rise_en,
    input  logic fall_en,
    input  logic clr_i,
    output logic pend_o
);
    localparam int SH_W = SYNC_STAGES + 1;

    logic [SH_W-1:0] sh_q;
    logic            cur, prev, hit;

    assign cur  = sh_q[SYNC_STAGES-1];
    assign prev = sh_q[SYNC_STAGES];
    assign hit  = (rise_en & cur & ~prev) | (fall_en & ~cur & prev);

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q   <= '0;
            pend_o <= 1'b0;
        end else begin
            sh_q <= {sh_q[SH_W-2:0], src_i};
            if (!rise_en && !fall_en)
                pend_o <= cur;
            else
                pend_o <= (pend_o & ~clr_i) | hit;
        end
    end
endmodule

// File: rtl/ic_prio_sel.sv
module ic_prio_sel
    import ic_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] act_i,
    input  logic            rot_en,
    input  logic            adv_i,
    output logic            vld_o,
    output logic [IDW-1:0]  id_o
);
    logic [IDW-1:0]    last_q;
    logic [IDW-1:0]    base;
    logic [2*NSRC-1:0] dbl;
    ic_pick_t          pick;

    always_comb begin
        base  = rot_en ? last_q + 1'b1 : '0;
        dbl   = {act_i, act_i} >> base;
        pick  = first_set(dbl[NSRC-1:0]);
        vld_o = pick.vld;
        id_o  = pick.vld ? pick.id + base : IDW'(NSRC - 1);
    end

    always_ff @(posedge clk) begin
        if (rst)
            last_q <= '1;
        else if (adv_i && vld_o)
            last_q <= id_o;
    end
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
    import ic_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] src_i,
    input  logic [7:0]      bus_addr,
    input  logic            bus_wr,
    input  logic [3:0]      bus_be,
    input  logic [31:0]     bus_wdata,
    output logic [31:0]     bus_rdata,
    output logic            irq_o,
    output logic            fiq_o
);
    localparam int LANES = 4;

    ic_ctrl_t        ctrl_q [NSRC];
    logic            rot_irq, rot_fiq;
    logic [NSRC-1:0] pend, clr, act_irq, act_fiq, edge_mode;
    logic            irq_vld, fiq_vld;
    logic [IDW-1:0]  irq_id, fiq_id;
    logic            wr_ctrl, wr_stat;
    logic            unused_addr;

    assign unused_addr = ^bus_addr[1:0];
    assign wr_ctrl     = bus_wr && bus_addr[7:6] == 2'b01;
    assign wr_stat     = bus_wr && bus_addr[7:3] == 5'b10000;

    // control bytes and rotation bits
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int n = 0; n < NSRC; n++) ctrl_q[n] <= '0;
            rot_irq <= 1'b0;
            rot_fiq <= 1'b0;
        end else begin
            for (int n = 0; n < NSRC; n++) begin
                if (wr_ctrl && bus_addr[5:2] == 4'(n / LANES) && bus_be[n % LANES])
                    ctrl_q[n] <= bus_wdata[8*(n % LANES) +: 8];
            end
            if (bus_wr && bus_addr[7:2] == 6'h08 && bus_be[0]) rot_irq <= bus_wdata[6];
            if (bus_wr && bus_addr[7:2] == 6'h09 && bus_be[0]) rot_fiq <= bus_wdata[6];
        end
    end

    for (genvar n = 0; n < NSRC; n++) begin : g_src
        localparam int BIT = n % 32;
        assign clr[n] = wr_stat && bus_addr[2] == (n >= 32)
                        && bus_be[BIT / 8] && bus_wdata[BIT];
        assign edge_mode[n] = ctrl_q[n].trig_rise | ctrl_q[n].trig_fall;
        assign act_irq[n]   = ctrl_q[n].en && pend[n] && ctrl_q[n].dest == DST_IRQ;
        assign act_fiq[n]   = ctrl_q[n].en && pend[n] && ctrl_q[n].dest == DST_FIQ;

        ic_src_chan #(.SYNC_STAGES(2)) u_chan (
            .clk     (clk),
            .rst     (rst),
            .src_i   (src_i[n]),
            .rise_en (ctrl_q[n].trig_rise),
            .fall_en (ctrl_q[n].trig_fall),
            .clr_i   (clr[n]),
            .pend_o  (pend[n])
        );
    end

    ic_prio_sel u_sel_irq (
        .clk(clk), .rst(rst), .act_i(act_irq), .rot_en(rot_irq),
        .adv_i(clr[irq_id]), .vld_o(irq_vld), .id_o(irq_id)
    );

    ic_prio_sel u_sel_fiq (
        .clk(clk), .rst(rst), .act_i(act_fiq), .rot_en(rot_fiq),
        .adv_i(clr[fiq_id]), .vld_o(fiq_vld), .id_o(fiq_id)
    );

    assign irq_o = |act_irq;
    assign fiq_o = |act_fiq;

    always_comb begin
        bus_rdata = '0;
        if (bus_addr[7:6] == 2'b01) begin
            for (int l = 0; l < LANES; l++)
                bus_rdata[8*l +: 8] = ctrl_q[{bus_addr[5:2], 2'(l)}];
        end else begin
            case (bus_addr[7:2])
                6'h08:   bus_rdata = {25'd0, rot_irq, irq_id};
                6'h09:   bus_rdata = {25'd0, rot_fiq, fiq_id};
                6'h20:   bus_rdata = pend[31:0];
                6'h21:   bus_rdata = pend[63:32];
                default: bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/irq_vec_ctrl_chk.sv
module irq_vec_ctrl_chk
    import ic_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            irq_o,
    input logic            fiq_o,
    input logic            irq_vld,
    input logic            fiq_vld,
    input logic [IDW-1:0]  irq_id,
    input logic [IDW-1:0]  fiq_id,
    input logic            rot_irq,
    input logic [NSRC-1:0] act_irq,
    input logic [NSRC-1:0] act_fiq,
    input logic [NSRC-1:0] pend,
    input logic [NSRC-1:0] clr,
    input logic [NSRC-1:0] edge_mode
);
    // R6
    irq_out_match_chk: assert property (@(posedge clk) disable iff (rst)
        irq_o == irq_vld);

    // R6
    fiq_out_match_chk: assert property (@(posedge clk) disable iff (rst)
        fiq_o == fiq_vld);

    // R7
    irq_win_active_chk: assert property (@(posedge clk) disable iff (rst)
        irq_vld |-> act_irq[irq_id]);

    // R7
    fiq_win_active_chk: assert property (@(posedge clk) disable iff (rst)
        fiq_vld |-> act_fiq[fiq_id]);

    // R7
    irq_fixed_lowest_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_vld && !rot_irq) |-> ((act_irq & ((64'd1 << irq_id) - 64'd1)) == '0));

    // R8
    irq_idle_code_chk: assert property (@(posedge clk) disable iff (rst)
        !irq_vld |-> irq_id == 6'd63);

    for (genvar i = 0; i < NSRC; i++) begin : g_sticky
        // R4
        edge_sticky_chk: assert property (@(posedge clk) disable iff (rst)
            (pend[i] && edge_mode[i] && !clr[i]) |=> pend[i]);
    end
endmodule

bind irq_vec_ctrl irq_vec_ctrl_chk u_chk (
    .clk(clk), .rst(rst), .irq_o(irq_o), .fiq_o(fiq_o),
    .irq_vld(irq_vld), .fiq_vld(fiq_vld), .irq_id(irq_id), .fiq_id(fiq_id),
    .rot_irq(rot_irq), .act_irq(act_irq), .act_fiq(act_fiq),
    .pend(pend), .clr(clr), .edge_mode(edge_mode)
);

// File: tb/irq_vec_ctrl_tb.sv
module irq_vec_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] src_i = '0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o, fiq_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    irq_vec_ctrl u_dut (
        .clk(clk), .rst(rst), .src_i(src_i), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_o(irq_o), .fiq_o(fiq_o)
    );

    // fixed-priority vectors: all sources enabled, level, IRQ
    localparam int NV = 6;
    localparam logic [63:0] TV_SRC [NV] = '{
        64'd0,
        64'd1 << 5,
        (64'd1 << 10) | (64'd1 << 40),
        64'd1 << 63,
        (64'd1 << 62) | (64'd1 << 63),
        '1
    };
    localparam logic [5:0] TV_ID  [NV] = '{6'd63, 6'd5, 6'd10, 6'd63, 6'd62, 6'd0};
    localparam logic       TV_OUT [NV] = '{1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1};

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_be = be; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_be = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(input int idx);
        @(negedge clk);
        src_i[idx] = 1'b1;
        idle(3);
        src_i[idx] = 1'b0;
        idle(4);
    endtask

    task automatic do_reset();
        @(negedge clk);
        src_i = '0;
        rst = 1'b1;
        idle(3);
        rst = 1'b0;
        idle(1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        do_reset();

        // R1 reset state
        rd(8'h40, r); check("R1 ctrl word 0x40", r, 32'h0);
        rd(8'h7C, r); check("R1 ctrl word 0x7C", r, 32'h0);
        rd(8'h80, r); check("R1 status lo", r, 32'h0);
        rd(8'h84, r); check("R1 status hi", r, 32'h0);
        rd(8'h20, r); check("R1 irq prio", r, 32'h3F);
        rd(8'h24, r); check("R1 fiq prio", r, 32'h3F);
        check("R1 irq_o", {31'd0, irq_o}, 32'd0);
        check("R1 fiq_o", {31'd0, fiq_o}, 32'd0);

        // R7 R8 vector table
        for (int w = 0; w < 16; w++) wr(8'h40 + 8'(4*w), 32'h08080808, 4'hF);
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            src_i = TV_SRC[i];
            idle(5);
            rd(8'h20, r);
            check($sformatf("R7 vector %0d id", i), {26'd0, r[5:0]}, {26'd0, TV_ID[i]});
            check($sformatf("R6 vector %0d irq_o", i), {31'd0, irq_o}, {31'd0, TV_OUT[i]});
            if (i == 0) begin
                rd(8'h84, r); check("R8 idle src63 status", {31'd0, r[31]}, 32'd0);
            end
            if (i == 3) begin
                rd(8'h84, r); check("R8 real src63 status", {31'd0, r[31]}, 32'd1);
            end
        end
        do_reset();

        // R2 byte lanes
        wr(8'h44, 32'hA5000000, 4'b1000);
        wr(8'h44, 32'h11223344, 4'b0001);
        rd(8'h44, r); check("R2 lane write readback", r, 32'hA5000044);
        wr(8'h44, 32'h0, 4'hF);

        // R3 level mode
        wr(8'h48, 32'h00000800, 4'b0010);
        @(negedge clk); src_i[9] = 1'b1;
        idle(5);
        rd(8'h80, r); check("R3 level status set", r, 32'h200);
        wr(8'h80, 32'h200, 4'hF);
        idle(2);
        rd(8'h80, r); check("R3 clear while high ignored", r, 32'h200);
        check("R3 irq_o while level high", {31'd0, irq_o}, 32'd1);
        @(negedge clk); src_i[9] = 1'b0;
        idle(5);
        rd(8'h80, r); check("R3 level status follows low", r, 32'h0);
        check("R3 irq_o after drop", {31'd0, irq_o}, 32'd0);

        // R4 rising, source 33
        wr(8'h60, 32'h00002800, 4'b0010);
        pulse(33);
        idle(2);
        rd(8'h84, r); check("R4 rising sticky", r, 32'h2);
        rd(8'h20, r); check("R4 irq prio src33", {26'd0, r[5:0]}, 32'd33);
        wr(8'h84, 32'h2, 4'b0001);
        rd(8'h84, r); check("R4 clear by write", r, 32'h0);
        check("R4 irq_o after clear", {31'd0, irq_o}, 32'd0);

        // R5 falling, source 40
        wr(8'h68, 32'h00000048, 4'b0001);
        @(negedge clk); src_i[40] = 1'b1;
        idle(6);
        rd(8'h84, r); check("R5 falling ignores rise", r, 32'h0);
        @(negedge clk); src_i[40] = 1'b0;
        idle(6);
        rd(8'h84, r); check("R5 falling captured", r, 32'h100);
        wr(8'h84, 32'h100, 4'b0010);
        wr(8'h68, 32'h00000068, 4'b0001);
        idle(2);
        @(negedge clk); src_i[40] = 1'b1;
        idle(6);
        rd(8'h84, r); check("R5 both edges rise", r, 32'h100);
        wr(8'h84, 32'h100, 4'b0010);
        @(negedge clk); src_i[40] = 1'b0;
        idle(6);
        rd(8'h84, r); check("R5 both edges fall", r, 32'h100);
        wr(8'h84, 32'h100, 4'b0010);
        wr(8'h68, 32'h0, 4'b0001);

        // R6 routing, source 12
        wr(8'h4C, 32'h00000009, 4'b0001);
        @(negedge clk); src_i[12] = 1'b1;
        idle(5);
        check("R6 fiq_o routed", {31'd0, fiq_o}, 32'd1);
        check("R6 irq_o not routed", {31'd0, irq_o}, 32'd0);
        rd(8'h24, r); check("R7 fiq prio src12", {26'd0, r[5:0]}, 32'd12);
        rd(8'h20, r); check("R8 irq idle while fiq busy", {26'd0, r[5:0]}, 32'd63);
        wr(8'h4C, 32'h0000000D, 4'b0001);
        check("R6 dest5 drives no fiq", {31'd0, fiq_o}, 32'd0);
        check("R6 dest5 drives no irq", {31'd0, irq_o}, 32'd0);
        rd(8'h4C, r); check("R6 dest5 stored", r, 32'h0D);
        rd(8'h80, r); check("R6 dest5 status kept", r, 32'h1000);
        wr(8'h4C, 32'h00000001, 4'b0001);
        check("R6 disabled drives no fiq", {31'd0, fiq_o}, 32'd0);
        @(negedge clk); src_i[12] = 1'b0;
        do_reset();

        // R9 rotation on IRQ: sources 3, 7, 20 rising
        wr(8'h40, 32'h28000000, 4'b1000);
        wr(8'h44, 32'h28000000, 4'b1000);
        wr(8'h54, 32'h00000028, 4'b0001);
        wr(8'h20, 32'h00000040, 4'b0001);
        rd(8'h20, r); check("R9 rotation idle read", r, 32'h7F);
        rd(8'h24, r); check("R10 fiq rotation independent", r, 32'h3F);
        pulse(3); pulse(7); pulse(20);
        rd(8'h20, r); check("R9 first pick from 0", r, 32'h43);
        wr(8'h80, 32'h8, 4'b0001);
        pulse(3);
        rd(8'h20, r); check("R9 after 3 picks 7", r, 32'h47);
        wr(8'h80, 32'h80, 4'b0001);
        rd(8'h20, r); check("R9 after 7 picks 20", r, 32'h54);
        wr(8'h80, 32'h100000, 4'b0100);
        rd(8'h20, r); check("R9 wraps to 3", r, 32'h43);

        // R10 FIQ rotation set alone keeps IRQ bit
        wr(8'h24, 32'h00000040, 4'b0001);
        rd(8'h24, r); check("R10 fiq rotation bit", r, 32'h7F);
        wr(8'h20, 32'h0, 4'b0001);
        rd(8'h24, r); check("R10 fiq bit kept", r, 32'h7F);
        rd(8'h20, r); check("R10 irq rotation off", r, 32'h03);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule